// File: doc/BRIEF.md
# Prioritised Address Window Chip-Select Decoder

This block sits between a processor's external address path and its memory devices. It checks every external access address against four programmable windows, chooses the bus configuration word of the highest-priority window that matches, and drives one of five active-low chip selects: one per window and one default select for addresses that fall in no window. It also drives the upper address pins (address bits 16 and above). How many of those pins it drives depends on the configured size of the external address space.

Each window has a base address, a size given as a power of two, and an enable bit. Higher-numbered windows win overlaps. The chip selects can come straight from the address through combinational logic (direct mode). They can also come from a register that captures the decode once at the start of an access and holds it until the access ends (filtered mode). In single-chip operation there is no external bus, so every chip select stays inactive and no upper address pin is driven.

Top module: `awcs_decoder`

## Requirements
- R1: Window w (w = 1..4, configured through slice w-1 of each window port) matches when its enable bit is 1 and the address bits at positions `win_szlog` and above equal those of its base. A disabled window never matches.
- R2: Priority among matching windows is 4 over 3 over 2 over 1. This covers the 3/4 group taking precedence over the 1/2 group.
- R3: An access that matches no window selects the default: `csn_o[0]` goes low and `sel_cfg_o` equals `dflt_cfg_i`.
- R4: `sel_cfg_o` equals the configuration word of the winning window, taken from slice w-1 of `win_cfg_i`.
- R5: Chip selects are active low. `csn_o[0]` is the default select and `csn_o[w]` belongs to window w. At most one of them is low at any time.
- R6: With `unlatched_i`=1 and a valid access, `csn_o` follows the current address in the same cycle, with no clock edge in between.
- R7: With `unlatched_i`=0, `csn_o` takes the decode at the first rising clock edge that samples `acc_valid_i` high. It then holds that value while `acc_valid_i` stays high, even if the address changes. It returns to all-high at the first edge that samples `acc_valid_i` low.
- R8: While no access is valid, or while `single_chip_i` is 1, all chip selects are high in both modes.
- R9: `space_sel_i` codes 0, 1, 2 and 3 (64 KB, 256 KB, 1 MB, 8 MB) enable 0, 2, 4 and 7 upper pins respectively, counted upward from `upa_o[0]`. An enabled pin i drives address bit 16+i. A pin that is not enabled has `upa_oe_o[i]`=0 and `upa_o[i]`=0.
- R10: Address bits at or above the configured space width (16, 18, 20 or 23 bits) take no part in window decoding.
- R11: While `single_chip_i` is 1, every bit of `upa_oe_o` is 0.
- R12: After reset, with no access valid, all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 23 | Access byte address |
| acc_valid_i | input | 1 | High for the duration of an external access |
| single_chip_i | input | 1 | No external bus: chip selects and upper pins off |
| unlatched_i | input | 1 | 1 = direct combinational chip selects, 0 = filtered |
| space_sel_i | input | 2 | External space size code (0:64 KB, 1:256 KB, 2:1 MB, 3:8 MB) |
| win_en_i | input | 4 | Window enables, bit w-1 for window w |
| win_base_i | input | 92 | Window base addresses, 23 bits each |
| win_szlog_i | input | 20 | Window size log2, 5 bits each |
| win_cfg_i | input | 64 | Window bus configuration words, 16 bits each |
| dflt_cfg_i | input | 16 | Default bus configuration word |
| csn_o | output | 5 | Active-low chip selects, bit 0 default |
| sel_cfg_o | output | 16 | Configuration word of the winning window |
| upa_o | output | 7 | Upper address pins (bits 16..22) |
| upa_oe_o | output | 7 | Output enables of the upper address pins |

## Verification
The hardest case to reach from the ports is filtered mode when the address moves to a different window during one access. The stimulus starts an access in window 1, changes the address into window 4 while keeping the access valid, and checks at later clock edges that the held select has not moved. Overlap priority between the two groups needs a window 3 that covers windows 1 and 2. The bench reprograms window 3 that way in the middle of the run. Masking of bits above the space width needs an address that would hit a window if those bits were counted, so the bench sets a high bit that would otherwise select window 4.

// File: rtl/awcs_pkg.sv
// Package: shared types and helpers for the address-window chip-select decoder.
// Assumes the external address carries at least 16 bits below the upper pins.
package awcs_pkg;

    localparam int unsigned NUM_WIN  = 4;
    localparam int unsigned LOW_BITS = 16;

    typedef enum logic [1:0] {
        SPACE_64K  = 2'd0,
        SPACE_256K = 2'd1,
        SPACE_1M   = 2'd2,
        SPACE_8M   = 2'd3
    } space_e;

    // Number of upper address pins driven for a given space size.
    function automatic int unsigned upper_lines(space_e s);
        case (s)
            SPACE_64K:  return 0;
            SPACE_256K: return 2;
            SPACE_1M:   return 4;
            default:    return 7;
        endcase
    endfunction

endpackage

// File: rtl/awcs_win_match.sv
// Module: single window comparator.
// Reports a hit when the window is enabled and every address bit at or above
// the window's size exponent equals the base. Exponents >= ADDR_W match all.
module awcs_win_match #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned SZ_W   = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SZ_W-1:0]   szlog_i,
    input  logic              en_i,
    output logic              hit_o
);

    logic [ADDR_W-1:0] keep_mask;

    // Build the mask of compared bits and evaluate the hit.
    always_comb begin
        for (int i = 0; i < int'(ADDR_W); i++) begin
            keep_mask[i] = (i >= int'(szlog_i));
        end
        hit_o = en_i && (((addr_i ^ base_i) & keep_mask) == '0);
    end

endmodule

// File: rtl/awcs_prio_sel.sv
// Module: fixed-priority resolver.
// Highest window index wins (4 > 3 > 2 > 1); no hit selects the default.
// Output one-hot bit 0 is the default, bit w is window w.
module awcs_prio_sel #(
    parameter int unsigned NW    = 4,
    parameter int unsigned CFG_W = 16,
    localparam int unsigned CSW  = NW + 1
) (
    input  logic [NW-1:0]       hit_i,
    input  logic [NW*CFG_W-1:0] cfg_i,
    input  logic [CFG_W-1:0]    dflt_cfg_i,
    output logic [CSW-1:0]      sel_oh_o,
    output logic [CFG_W-1:0]    sel_cfg_o
);

    // Scan upward so that the last (highest) matching window overrides.
    always_comb begin
        sel_oh_o    = '0;
        sel_oh_o[0] = 1'b1;
        sel_cfg_o   = dflt_cfg_i;
        for (int j = 0; j < int'(NW); j++) begin
            if (hit_i[j]) begin
                sel_oh_o      = '0;
                sel_oh_o[j+1] = 1'b1;
                sel_cfg_o     = cfg_i[j*CFG_W +: CFG_W];
            end
        end
    end

endmodule

// File: rtl/awcs_cs_stage.sv
// Module: chip-select output stage.
// Direct mode passes the decode straight through while an access is valid.
// Filtered mode captures the decode once at the first valid edge and holds it
// until the access ends. Assumes acc_valid_i is glitch-free at clock edges.
module awcs_cs_stage #(
    parameter int unsigned CSW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic           single_i,
    input  logic           unlatched_i,
    input  logic [CSW-1:0] sel_oh_i,
    output logic [CSW-1:0] csn_o
);

    logic           active_q;
    logic [CSW-1:0] csn_q;
    logic [CSW-1:0] csn_direct;
    logic           live;

    // Whether an external access is in progress.
    always_comb live = valid_i && !single_i;

    // Combinational chip selects for direct mode.
    always_comb csn_direct = live ? ~sel_oh_i : '1;

    // Filtered register: capture at the start of the access, release at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q    <= '1;
            active_q <= 1'b0;
        end else if (!live) begin
            csn_q    <= '1;
            active_q <= 1'b0;
        end else if (!active_q) begin
            csn_q    <= ~sel_oh_i;
            active_q <= 1'b1;
        end
    end

    // Output mux between the two modes.
    always_comb csn_o = unlatched_i ? csn_direct : csn_q;

    // R7: once captured, the filtered value holds while the access continues.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && live) |=> $stable(csn_q));

    // R7: an edge that samples no valid access releases the filtered selects.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!live) |=> (csn_q == '1));

    // R8: in direct mode, no access means no select.
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlatched_i && !live) |-> (csn_o == '1));

endmodule

// File: rtl/awcs_upper_pins.sv
// Module: upper address pin driver.
// Enables as many pins above bit 15 as the space size allows; pins that are
// not enabled drive zero. Single-chip operation disables every pin.
module awcs_upper_pins #(
    parameter int unsigned ADDR_W = 23,
    localparam int unsigned UW    = ADDR_W - awcs_pkg::LOW_BITS
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  awcs_pkg::space_e      space_i,
    input  logic                  single_i,
    output logic [UW-1:0]         upa_o,
    output logic [UW-1:0]         upa_oe_o
);

    int unsigned lines;

    // Work out the enabled pins and their driven values.
    always_comb begin
        lines = awcs_pkg::upper_lines(space_i);
        for (int i = 0; i < int'(UW); i++) begin
            upa_oe_o[i] = !single_i && (i < int'(lines));
            upa_o[i]    = upa_oe_o[i] ? addr_i[awcs_pkg::LOW_BITS + i] : 1'b0;
        end
    end

endmodule

// File: rtl/awcs_decoder.sv
// Module: top of the prioritised address-window chip-select decoder.
// Masks the address to the configured space width, compares it against four
// windows, resolves priority, and drives chip selects, the selected bus
// configuration word and the upper address pins.
module awcs_decoder #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned CFG_W  = 16,
    parameter int unsigned SZ_W   = 5,
    localparam int unsigned NW    = awcs_pkg::NUM_WIN,
    localparam int unsigned CSW   = NW + 1,
    localparam int unsigned UW    = ADDR_W - awcs_pkg::LOW_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  acc_valid_i,
    input  logic                  single_chip_i,
    input  logic                  unlatched_i,
    input  logic [1:0]            space_sel_i,
    input  logic [NW-1:0]         win_en_i,
    input  logic [NW*ADDR_W-1:0]  win_base_i,
    input  logic [NW*SZ_W-1:0]    win_szlog_i,
    input  logic [NW*CFG_W-1:0]   win_cfg_i,
    input  logic [CFG_W-1:0]      dflt_cfg_i,
    output logic [CSW-1:0]        csn_o,
    output logic [CFG_W-1:0]      sel_cfg_o,
    output logic [UW-1:0]         upa_o,
    output logic [UW-1:0]         upa_oe_o
);

    awcs_pkg::space_e   space;
    logic [ADDR_W-1:0]  space_mask;
    logic [ADDR_W-1:0]  dec_addr;
    logic [NW-1:0]      win_hit;
    logic [CSW-1:0]     sel_oh;

    // Decode the space code and clear address bits beyond the space width.
    always_comb begin
        space = awcs_pkg::space_e'(space_sel_i);
        for (int i = 0; i < int'(ADDR_W); i++) begin
            space_mask[i] = (i < int'(awcs_pkg::LOW_BITS + awcs_pkg::upper_lines(space)));
        end
        dec_addr = addr_i & space_mask;
    end

    // One comparator per window.
    for (genvar w = 0; w < int'(NW); w++) begin : g_win
        awcs_win_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
            .addr_i  (dec_addr),
            .base_i  (win_base_i[w*ADDR_W +: ADDR_W]),
            .szlog_i (win_szlog_i[w*SZ_W +: SZ_W]),
            .en_i    (win_en_i[w]),
            .hit_o   (win_hit[w])
        );
    end

    awcs_prio_sel #(.NW(NW), .CFG_W(CFG_W)) u_prio (
        .hit_i      (win_hit),
        .cfg_i      (win_cfg_i),
        .dflt_cfg_i (dflt_cfg_i),
        .sel_oh_o   (sel_oh),
        .sel_cfg_o  (sel_cfg_o)
    );

    awcs_cs_stage #(.CSW(CSW)) u_cs (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (acc_valid_i),
        .single_i    (single_chip_i),
        .unlatched_i (unlatched_i),
        .sel_oh_i    (sel_oh),
        .csn_o       (csn_o)
    );

    awcs_upper_pins #(.ADDR_W(ADDR_W)) u_upa (
        .addr_i   (addr_i),
        .space_i  (space),
        .single_i (single_chip_i),
        .upa_o    (upa_o),
        .upa_oe_o (upa_oe_o)
    );

    // R5: never more than one chip select low.
    p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~csn_o));

    // R2: a window-4 hit always reaches the window-4 select in direct mode.
    p_top_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit[NW-1] && acc_valid_i && !single_chip_i && unlatched_i)
            |-> !csn_o[CSW-1]);

    // R3: no hit during a direct-mode access drives the default select.
    p_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_hit == '0) && acc_valid_i && !single_chip_i && unlatched_i)
            |-> !csn_o[0]);

    // R11: single-chip operation drives no upper pin.
    p_upa_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        single_chip_i |-> (upa_oe_o == '0));

endmodule

// File: tb/awcs_decoder_tb_top.sv
`timescale 1ns/1ps
module awcs_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [22:0] addr_i = '0;
    logic        acc_valid_i = 1'b0;
    logic        single_chip_i = 1'b0;
    logic        unlatched_i = 1'b1;
    logic [1:0]  space_sel_i = 2'd3;
    logic [3:0]  win_en_i;
    logic [91:0] win_base_i;
    logic [19:0] win_szlog_i;
    logic [63:0] win_cfg_i;
    logic [15:0] dflt_cfg_i = 16'h0D0D;
    logic [4:0]  csn_o;
    logic [15:0] sel_cfg_o;
    logic [6:0]  upa_o;
    logic [6:0]  upa_oe_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [22:0] w_base [4];
    logic [4:0]  w_szl  [4];
    logic        w_en   [4];

    always #2.5 clk = ~clk;

    awcs_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .acc_valid_i(acc_valid_i),
        .single_chip_i(single_chip_i), .unlatched_i(unlatched_i),
        .space_sel_i(space_sel_i), .win_en_i(win_en_i), .win_base_i(win_base_i),
        .win_szlog_i(win_szlog_i), .win_cfg_i(win_cfg_i), .dflt_cfg_i(dflt_cfg_i),
        .csn_o(csn_o), .sel_cfg_o(sel_cfg_o), .upa_o(upa_o), .upa_oe_o(upa_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_csn(input int idx);
        return 5'h1F ^ (5'b1 << idx);
    endfunction

    function automatic logic [15:0] exp_cfg(input int idx);
        return (idx == 0) ? 16'h0D0D : 16'hC100 + 16'(idx - 1);
    endfunction

    task automatic apply_cfg();
        for (int j = 0; j < 4; j++) begin
            win_base_i[j*23 +: 23] = w_base[j];
            win_szlog_i[j*5 +: 5]  = w_szl[j];
            win_en_i[j]            = w_en[j];
            win_cfg_i[j*16 +: 16]  = 16'hC100 + 16'(j);
        end
    endtask

    task automatic default_cfg();
        w_base[0] = 23'h010000; w_szl[0] = 5'd16; w_en[0] = 1'b1;
        w_base[1] = 23'h018000; w_szl[1] = 5'd15; w_en[1] = 1'b1;
        w_base[2] = 23'h040000; w_szl[2] = 5'd18; w_en[2] = 1'b1;
        w_base[3] = 23'h050000; w_szl[3] = 5'd16; w_en[3] = 1'b1;
        apply_cfg();
    endtask

    // Direct-mode decode of one address; expected window index given by caller.
    task automatic direct(input logic [22:0] a, input int idx, input string tag);
        @(negedge clk);
        unlatched_i = 1'b1; acc_valid_i = 1'b1; addr_i = a;
        #1;
        chk({tag, " csn"}, 32'(csn_o), 32'(exp_csn(idx)));
        chk({tag, " cfg"}, 32'(sel_cfg_o), 32'(exp_cfg(idx)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 reset csn", 32'(csn_o), 32'h1F);
    endtask

    task automatic t_windows();
        default_cfg();
        space_sel_i = 2'd3;
        direct(23'h012000, 1, "R1 window1 hit");
        direct(23'h045000, 3, "R1 window3 hit");
        direct(23'h018100, 2, "R2 window2 over window1");
        direct(23'h01FFFF, 2, "R2 top edge window2");
        direct(23'h050010, 4, "R2 window4 over window3");
        direct(23'h00FFFF, 0, "R3 below window1 default");
        direct(23'h100000, 0, "R3 no window default");
        direct(23'h060000, 3, "R4 window3 cfg");
        direct(23'h012000, 1, "R6 direct follows address");
    endtask

    task automatic t_disabled();
        w_en[3] = 1'b0; apply_cfg();
        direct(23'h050010, 3, "R1 disabled window4");
        default_cfg();
    endtask

    task automatic t_group();
        w_base[2] = 23'h000000; w_szl[2] = 5'd17; apply_cfg();
        direct(23'h018100, 3, "R2 group34 over window2");
        direct(23'h012000, 3, "R2 group34 over window1");
        default_cfg();
    endtask

    task automatic t_idle();
        @(negedge clk);
        unlatched_i = 1'b1; acc_valid_i = 1'b0; addr_i = 23'h012000;
        #1 chk("R8 direct idle", 32'(csn_o), 32'h1F);
        @(negedge clk);
        acc_valid_i = 1'b1; single_chip_i = 1'b1;
        #1 chk("R8 direct single chip", 32'(csn_o), 32'h1F);
        chk("R11 single chip no upper pins", 32'(upa_oe_o), 32'h0);
        @(negedge clk);
        unlatched_i = 1'b0;
        @(negedge clk);
        chk("R8 filtered single chip", 32'(csn_o), 32'h1F);
        single_chip_i = 1'b0; acc_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_filtered();
        @(negedge clk);
        unlatched_i = 1'b0; acc_valid_i = 1'b0;
        @(negedge clk);
        addr_i = 23'h012000; acc_valid_i = 1'b1;
        #1 chk("R7 before capture edge", 32'(csn_o), 32'h1F);
        @(negedge clk);
        chk("R7 captured window1", 32'(csn_o), 32'(exp_csn(1)));
        addr_i = 23'h050010;
        @(negedge clk);
        chk("R7 hold on address change", 32'(csn_o), 32'(exp_csn(1)));
        @(negedge clk);
        chk("R7 still held", 32'(csn_o), 32'(exp_csn(1)));
        acc_valid_i = 1'b0;
        #1 chk("R7 held until edge", 32'(csn_o), 32'(exp_csn(1)));
        @(negedge clk);
        chk("R7 released", 32'(csn_o), 32'h1F);
        acc_valid_i = 1'b1;
        @(negedge clk);
        chk("R7 new access window4", 32'(csn_o), 32'(exp_csn(4)));
        acc_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_space();
        @(negedge clk);
        unlatched_i = 1'b1; acc_valid_i = 1'b0; addr_i = 23'h5ABCDE;
        space_sel_i = 2'd3;
        #1 chk("R9 8M oe", 32'(upa_oe_o), 32'h7F);
        chk("R9 8M pins", 32'(upa_o), 32'h5A);
        space_sel_i = 2'd2;
        #1 chk("R9 1M oe", 32'(upa_oe_o), 32'h0F);
        chk("R9 1M pins", 32'(upa_o), 32'h0A);
        space_sel_i = 2'd1;
        #1 chk("R9 256K oe", 32'(upa_oe_o), 32'h03);
        chk("R9 256K pins", 32'(upa_o), 32'h02);
        space_sel_i = 2'd0;
        #1 chk("R9 64K oe", 32'(upa_oe_o), 32'h00);
        chk("R9 64K pins", 32'(upa_o), 32'h00);
    endtask

    task automatic t_mask();
        space_sel_i = 2'd0;
        direct(23'h041234, 0, "R10 64K masks window3");
        space_sel_i = 2'd1;
        direct(23'h051000, 1, "R10 256K masks to window1");
        space_sel_i = 2'd2;
        direct(23'h041234, 3, "R10 1M keeps window3");
        space_sel_i = 2'd3;
        @(negedge clk);
        acc_valid_i = 1'b0;
    endtask

    initial begin
        default_cfg();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_windows();
        t_disabled();
        t_group();
        t_idle();
        t_filtered();
        t_space();
        t_mask();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule